// File: doc/BRIEF.md
# RS-485 Reply Frame Sender with CRC-16

This block sends a reply frame on a half-duplex RS-485 link. A controller places N payload bytes in a frame buffer and pulses a send request with the length. The block reads the payload through a combinational read port and computes the CRC-16 as the bytes go out. It hands each byte to an external UART transmitter, and after the payload it sends the two check bytes. The line driver enable is held only while the frame is on the wire.

Some requests are refused outright: an empty or oversized length, a request made while the node is in listen-only mode, and a reply whose address byte is zero, which is a broadcast. A refused request leaves the bus released and the counters untouched.

Driver enable rises first. A programmable guard time follows, so the driver settles before the first start bit. The first byte goes to the UART once its data register is empty. Each later byte goes when the UART reports that the previous character has fully left. Driver enable is released only after the completion event of the last check byte.

Top module: `rs485_frame_tx`

## Requirements
- R1: The check value is CRC-16 with reflected polynomial 0xA001 and start value 0xFFFF, taken over the N payload bytes. It is sent low byte first, then high byte. For payload 0A 01 00 00 00 0B the two trailing bytes are 7C then B6.
- R2: An accepted frame writes exactly N+2 bytes to the UART: buffer entries 0 to N-1 in index order, then the two check bytes.
- R3: A request with length 0, or with length above DEPTH-2, is refused. Neither driver enable nor busy rises, and no byte is written.
- R4: A request made while `listen_only_i` is high is refused in the same way.
- R5: A request whose buffer entry 0 (the address byte) equals 0x00 is refused in the same way.
- R6: Driver enable rises in the cycle after an accepted request. `uart_wr_o` is never high unless driver enable is high. The first write comes no earlier than GUARD_CYCLES+1 cycles after driver enable rose.
- R7: The first byte is written only in the cycle after a clock edge at which `uart_empty_i` was high. While `uart_empty_i` stays low, the first write is held off.
- R8: Each byte after the first is written in the cycle after the `uart_tx_done_i` pulse of the preceding byte.
- R9: Driver enable and busy fall in the cycle after the `uart_tx_done_i` pulse of the final check byte. A `uart_tx_done_i` pulse while idle has no effect.
- R10: `sent_cnt_o` rises by one for every byte written to the UART and wraps modulo 2^CNT_W. It is zero after reset.
- R11: `busy_o` is high from the cycle after an accepted request until driver enable falls. A send request while busy is ignored, including one that arrives together with the final completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_i | input | 1 | Request to send the buffered frame |
| len_i | input | $clog2(DEPTH+1) | Payload length N, sampled with the request |
| listen_only_i | input | 1 | Node is in listen-only mode; replies are refused |
| buf_addr_o | output | $clog2(DEPTH) | Frame buffer read index |
| buf_data_i | input | 8 | Frame buffer byte at `buf_addr_o` (combinational) |
| uart_empty_i | input | 1 | UART data register can accept a byte |
| uart_tx_done_i | input | 1 | One-cycle pulse: last written character has fully left |
| uart_wr_o | output | 1 | One-cycle write strobe to the UART |
| uart_data_o | output | 8 | Byte written with `uart_wr_o` |
| drv_en_o | output | 1 | RS-485 line driver enable |
| busy_o | output | 1 | Frame in progress |
| sent_cnt_o | output | CNT_W | Count of bytes written to the UART, wrapping |

## Verification
Two kinds of event can land on the same clock edge. One is the completion pulse of the final check byte, which ends the frame and releases the driver. The other is a fresh send request, which would start a new frame if the block were idle. The bench raises the send request exactly in the cycle where its UART model issues the final completion pulse. It then checks, against its own cycle model, that driver enable falls on time, that no new frame starts and that no byte follows. A second overlap is also provoked: a send request during the guard and transmit phases of a long frame, which must leave the running frame undisturbed.

// File: rtl/rs485_frame_tx.sv
module rs485_frame_tx #(
  parameter int DEPTH        = 16,
  parameter int GUARD_CYCLES = 8,
  parameter int CNT_W        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       send_i,
  input  logic [$clog2(DEPTH+1)-1:0] len_i,
  input  logic                       listen_only_i,
  output logic [$clog2(DEPTH)-1:0]   buf_addr_o,
  input  logic [7:0]                 buf_data_i,
  input  logic                       uart_empty_i,
  input  logic                       uart_tx_done_i,
  output logic                       uart_wr_o,
  output logic [7:0]                 uart_data_o,
  output logic                       drv_en_o,
  output logic                       busy_o,
  output logic [CNT_W-1:0]           sent_cnt_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam int GW = $clog2(GUARD_CYCLES+1);
  localparam int HW = $clog2(GUARD_CYCLES+2);
  localparam logic [LW-1:0] MAX_LEN = LW'(DEPTH-2);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYCLES-1);
  localparam logic [HW-1:0] AGE_SAT = HW'(GUARD_CYCLES+1);

  typedef enum logic [1:0] {S_IDLE, S_GUARD, S_WAIT_EMPTY, S_WAIT_DONE} state_t;

  state_t          state;
  logic [LW-1:0]   idx;
  logic [LW-1:0]   len_q;
  logic [15:0]     crc;
  logic [GW-1:0]   gcnt;
  logic [LW-1:0]   nidx;
  logic            last;
  logic            accept;
  logic            load;
  logic [7:0]      byte_sel;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  assign nidx       = (state == S_WAIT_DONE) ? idx + LW'(1) : idx;
  assign buf_addr_o = nidx[AW-1:0];
  assign last       = (idx == len_q + LW'(1));
  assign busy_o     = (state != S_IDLE);

  assign accept = send_i && (len_i != '0) && (len_i <= MAX_LEN) &&
                  !listen_only_i && (buf_data_i != 8'h00);

  assign load = ((state == S_WAIT_EMPTY) && uart_empty_i) ||
                ((state == S_WAIT_DONE) && uart_tx_done_i && !last);

  always_comb begin
    if (nidx < len_q)       byte_sel = buf_data_i;
    else if (nidx == len_q) byte_sel = crc[7:0];
    else                    byte_sel = crc[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      len_q       <= '0;
      crc         <= 16'hFFFF;
      gcnt        <= '0;
      uart_wr_o   <= 1'b0;
      uart_data_o <= 8'h00;
      drv_en_o    <= 1'b0;
      sent_cnt_o  <= '0;
    end else begin
      uart_wr_o <= 1'b0;
      if (load) begin
        uart_wr_o   <= 1'b1;
        uart_data_o <= byte_sel;
        sent_cnt_o  <= sent_cnt_o + CNT_W'(1);
        idx         <= nidx;
        if (nidx < len_q) crc <= crc_step(crc, buf_data_i);
      end
      case (state)
        S_IDLE: if (accept) begin
          state    <= S_GUARD;
          len_q    <= len_i;
          crc      <= 16'hFFFF;
          gcnt     <= GUARD_LOAD;
          idx      <= '0;
          drv_en_o <= 1'b1;
        end
        S_GUARD: begin
          if (gcnt == '0) state <= S_WAIT_EMPTY;
          else            gcnt  <= gcnt - GW'(1);
        end
        S_WAIT_EMPTY: if (uart_empty_i) state <= S_WAIT_DONE;
        S_WAIT_DONE: if (uart_tx_done_i && last) begin
          state    <= S_IDLE;
          drv_en_o <= 1'b0;
          idx      <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [HW-1:0] de_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              de_age <= '0;
    else if (!drv_en_o)      de_age <= '0;
    else if (de_age != AGE_SAT) de_age <= de_age + HW'(1);
  end

  p_wr_needs_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uart_wr_o |-> drv_en_o);

  p_guard_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uart_wr_o |-> (de_age == AGE_SAT));

  p_first_after_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_EMPTY && !uart_empty_i) |=> !uart_wr_o);

  p_next_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_DONE && uart_tx_done_i && !last) |=> uart_wr_o);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT_DONE && uart_tx_done_i && last) |=> (!drv_en_o && !busy_o && !uart_wr_o));

  p_idle_done_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !send_i) |=> (!busy_o && !uart_wr_o));

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uart_wr_o |-> (sent_cnt_o == $past(sent_cnt_o) + CNT_W'(1)));

  p_refuse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && send_i && (len_i == '0 || len_i > MAX_LEN)) |=> !drv_en_o);

  p_refuse_listen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && listen_only_i) |=> !drv_en_o);

  p_busy_de_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == drv_en_o);

endmodule

// File: tb/rs485_frame_tx_tb.sv
module rs485_frame_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int G = 3;
  localparam int CNT_W = 5;
  localparam int BYTE_CYC = 6;
  localparam int LW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);

  logic clk = 0;
  logic rst_n = 0;
  logic task_start = 0, coll_start = 0, send_i;
  logic [LW-1:0] len_i = '0;
  logic listen_only = 0;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic u_empty = 1, hold_empty = 0, uart_empty;
  logic u_done = 0, spur_done = 0, uart_done;
  logic uart_wr;
  logic [7:0] uart_data;
  logic drv_en, busy;
  logic [CNT_W-1:0] sent_cnt;

  logic [7:0] mem [DEPTH];
  int checks = 0, failures = 0;

  assign send_i = task_start | coll_start;
  assign uart_empty = u_empty & ~hold_empty;
  assign uart_done = u_done | spur_done;
  assign buf_data = mem[buf_addr];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs485_frame_tx #(.DEPTH(DEPTH), .GUARD_CYCLES(G), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .send_i(send_i), .len_i(len_i),
    .listen_only_i(listen_only), .buf_addr_o(buf_addr), .buf_data_i(buf_data),
    .uart_empty_i(uart_empty), .uart_tx_done_i(uart_done), .uart_wr_o(uart_wr),
    .uart_data_o(uart_data), .drv_en_o(drv_en), .busy_o(busy), .sent_cnt_o(sent_cnt));

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      c ^= {8'h00, q[i]};
      for (int k = 0; k < 8; k++) begin
        if (c[0]) c = (c >> 1) ^ 16'hA001;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  function automatic bit acc_ok(input int n, input bit lo, input logic [7:0] b0);
    return (n != 0) && (n <= DEPTH-2) && !lo && (b0 != 8'h00);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural cycle model
  bit m_act = 0, m_first = 0, m_wr = 0;
  int m_left = 0, m_age = 0, m_sent = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 0; m_first <= 0; m_wr <= 0; m_left <= 0; m_age <= 0; m_sent <= 0;
    end else begin
      m_wr <= 0;
      if (!m_act) begin
        if (send_i && acc_ok(int'(len_i), listen_only, mem[0])) begin
          m_act <= 1; m_left <= int'(len_i) + 2; m_age <= 0; m_first <= 0;
        end
      end else begin
        m_age <= m_age + 1;
        if (!m_first && m_age >= G && uart_empty) begin
          m_wr <= 1; m_first <= 1; m_sent <= m_sent + 1;
        end
        if (uart_done && m_first) begin
          if (m_left == 1) m_act <= 0;
          else begin m_wr <= 1; m_sent <= m_sent + 1; end
          m_left <= m_left - 1;
        end
      end
    end
  end

  // UART model
  int u_timer = 0;
  bit collide_arm = 0;
  always @(negedge clk) begin
    u_done = 0;
    coll_start = 0;
    if (uart_wr) begin
      u_empty = 0;
      u_timer = BYTE_CYC;
    end else if (u_timer > 0) begin
      u_timer--;
      if (u_timer == 0) begin
        u_done = 1;
        u_empty = 1;
        if (collide_arm && m_left == 1) begin
          coll_start = 1;
          collide_arm = 0;
        end
      end
    end
  end

  // per-cycle comparison and byte capture
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  int exp_idx = 0;
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en) begin
      check(drv_en == m_act, "R6/R9", "drv_en", drv_en, m_act);
      check(busy == m_act, "R11", "busy", busy, m_act);
      check(uart_wr == m_wr, "R7/R8", "uart_wr", uart_wr, m_wr);
      check(sent_cnt == CNT_W'(m_sent), "R10", "sent_cnt", sent_cnt, m_sent % (1 << CNT_W));
      if (uart_wr) begin
        rx_q.push_back(uart_data);
        if (exp_idx < exp_q.size())
          check(uart_data == exp_q[exp_idx], "R2", "byte", uart_data, exp_q[exp_idx]);
        else
          check(0, "R2", "extra byte", uart_data, 0);
        exp_idx++;
      end
    end
  end

  task automatic run_frame(input logic [7:0] q[$], input int n, input bit lo,
                           input bit hold, input bit mid, input bit coll);
    logic [15:0] c;
    int sent0;
    for (int i = 0; i < DEPTH; i++) mem[i] = (i < q.size()) ? q[i] : 8'h00;
    exp_q.delete(); rx_q.delete(); exp_idx = 0;
    if (acc_ok(n, lo, mem[0])) begin
      for (int i = 0; i < n; i++) exp_q.push_back(mem[i]);
      c = ref_crc(exp_q);
      exp_q.push_back(c[7:0]);
      exp_q.push_back(c[15:8]);
    end
    sent0 = m_sent;
    collide_arm = coll;
    @(negedge clk);
    len_i = LW'(n); listen_only = lo; task_start = 1;
    if (hold) hold_empty = 1;
    @(negedge clk);
    task_start = 0;
    if (hold) begin
      repeat (20) @(negedge clk);
      check(rx_q.size() == 0, "R7", "write while UART full", rx_q.size(), 0);
      hold_empty = 0;
    end
    if (mid) begin
      repeat (G + 8) @(negedge clk);
      task_start = 1;
      @(negedge clk);
      task_start = 0;
    end
    repeat (2) @(negedge clk);
    while (m_act) @(negedge clk);
    repeat (4) @(negedge clk);
    listen_only = 0;
    check(rx_q.size() == exp_q.size(), "R2", "frame length", rx_q.size(), exp_q.size());
    check(!busy && !drv_en, "R9", "released after frame", busy, 0);
    check(m_sent - sent0 == exp_q.size(), "R10", "bytes counted", m_sent - sent0, exp_q.size());
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!drv_en && !busy && !uart_wr && sent_cnt == '0, "R10", "reset state",
          {drv_en, busy, uart_wr}, 0);
    rst_n = 1;
    cmp_en = 1;
    repeat (2) @(negedge clk);

    // R1 R2: known vector
    q = '{8'h0A, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0B};
    run_frame(q, 6, 0, 0, 0, 0);
    if (rx_q.size() == 8) begin
      check(rx_q[6] == 8'h7C, "R1", "crc low", rx_q[6], 8'h7C);
      check(rx_q[7] == 8'hB6, "R1", "crc high", rx_q[7], 8'hB6);
    end else check(0, "R1", "length", rx_q.size(), 8);

    q = '{8'h0A, 8'h05, 8'h00, 8'h02, 8'h00, 8'h00};
    run_frame(q, 6, 0, 0, 0, 0);
    if (rx_q.size() == 8) begin
      check(rx_q[6] == 8'h6D, "R1", "crc low", rx_q[6], 8'h6D);
      check(rx_q[7] == 8'h71, "R1", "crc high", rx_q[7], 8'h71);
    end else check(0, "R1", "length", rx_q.size(), 8);

    // R2 R3: maximum length accepted, single byte accepted
    q.delete();
    for (int i = 0; i < DEPTH-2; i++) q.push_back(8'(8'h11 * (i + 1) + 8'h03));
    run_frame(q, DEPTH-2, 0, 0, 0, 0);
    q = '{8'h2F};
    run_frame(q, 1, 0, 0, 0, 0);

    // R3: refused lengths
    q = '{8'h0A, 8'h03, 8'h00};
    run_frame(q, 0, 0, 0, 0, 0);
    check(rx_q.size() == 0, "R3", "len 0 refused", rx_q.size(), 0);
    run_frame(q, DEPTH-1, 0, 0, 0, 0);
    check(rx_q.size() == 0, "R3", "len over limit refused", rx_q.size(), 0);

    // R4: listen-only
    run_frame(q, 3, 1, 0, 0, 0);
    check(rx_q.size() == 0, "R4", "listen-only refused", rx_q.size(), 0);

    // R5: broadcast address
    q = '{8'h00, 8'h06, 8'h00, 8'h01};
    run_frame(q, 4, 0, 0, 0, 0);
    check(rx_q.size() == 0, "R5", "broadcast refused", rx_q.size(), 0);

    // R7: UART register full at start
    q = '{8'h44, 8'h10, 8'hFF, 8'h00};
    run_frame(q, 4, 0, 1, 0, 0);

    // R11: request during a frame
    q = '{8'h0A, 8'h03, 8'h00, 8'h02, 8'h00, 8'h02, 8'h04, 8'hB0};
    run_frame(q, 8, 0, 0, 1, 0);

    // R11 R9: request in the same cycle as the final completion pulse
    run_frame(q, 5, 0, 0, 0, 1);
    check(collide_arm == 0, "R11", "collision provoked", collide_arm, 0);

    // R9: completion pulse while idle
    @(negedge clk); spur_done = 1;
    @(negedge clk); spur_done = 0;
    repeat (6) @(negedge clk);
    check(!busy && !drv_en, "R9", "idle done ignored", busy, 0);

    // R10: wrap of the narrow counter
    check(sent_cnt == CNT_W'(m_sent) && m_sent >= (1 << CNT_W), "R10", "counter wrapped",
          sent_cnt, m_sent % (1 << CNT_W));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule